// File: doc/BRIEF.md
# Banked Register Context Switcher

This block keeps several complete register contexts for a core. The core works on a single live register file of 32 entries, each 64 bits wide. Behind that file sits a context store with one slot per context. When the core asks for a different context, the block first copies the live registers into the slot of the context that is running. It then fills the live file from the slot of the requested context. Each cycle moves one group of eight registers. Code on the core only ever sees the 32 live registers, so the result looks the same as saving to memory and restoring from it.

The pipeline has one write port and one registered read port on the live file. While a switch is in progress the block raises `busy`, which the pipeline uses as its stall. During that time `sw_ready` is low, new requests are refused, and pipeline writes are dropped. When the switch finishes, `done` pulses for one cycle and `cur_ctx` shows the new context in that same cycle. A request for the context that is already running moves no data and completes on the next cycle.

Top module: `ctx_switcher`

## Requirements
- R1: Reset (synchronous, active high) leaves `cur_ctx` = 0, `busy` = 0, `done` = 0, `sw_ready` = 1 and every live register reading 0. A context that has never been saved loads as all-zero registers.
- R2: A pipeline write (`pipe_we`, `pipe_waddr`, `pipe_wdata`) updates the live register at the clock edge. `pipe_rdata` shows the register addressed by `pipe_raddr` one clock edge after the address is presented.
- R3: A request (`sw_req` high while `sw_ready` is high) whose `sw_ctx` differs from `cur_ctx` raises `busy` on the next cycle. `busy` then stays high for exactly 9 cycles: four 8-register saves, four 8-register loads, and one cycle to finish writing the last load.
- R4: In the cycle right after the last busy cycle, `done` is 1 for one cycle, `busy` is 0, and `cur_ctx` equals the requested context. `cur_ctx` never changes in a cycle where `done` is 0.
- R5: After a switch, the live file holds exactly the registers the target context had when it was last switched out. The contexts saved earlier, and the state of the other contexts, are kept across any number of switches.
- R6: A request whose `sw_ctx` equals `cur_ctx` gives `done` = 1 on the next cycle, never raises `busy`, and leaves every live register unchanged.
- R7: `sw_ready` is low whenever `busy` is high. Requests made while `sw_ready` is low are ignored: they cause no later switch and do not change the target of the switch in progress.
- R8: Pipeline writes made while `busy` is high are ignored. The register ends up with the value loaded from the target context.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_req | input | 1 | Request a switch to `sw_ctx` |
| sw_ctx | input | 2 | Requested context id |
| sw_ready | output | 1 | High when a request can be accepted |
| busy | output | 1 | Switch in progress; pipeline stall |
| done | output | 1 | One-cycle pulse when a switch completes |
| cur_ctx | output | 2 | Context currently held in the live file |
| pipe_we | input | 1 | Pipeline write enable |
| pipe_waddr | input | 5 | Pipeline write register number |
| pipe_wdata | input | 64 | Pipeline write data |
| pipe_raddr | input | 5 | Pipeline read register number |
| pipe_rdata | output | 64 | Registered read data |

## Verification
Several kinds of internal fault show up at the ports in different ways:

- **Wrong slot row, group index or validity flag:** this stores registers in the wrong place. It is invisible until the affected context is switched back in. Then a read returns another context's value, or zero, in the group that went wrong.
- **Miscounted sequencer:** this shows at once as a busy window that is not exactly nine cycles long, or as a missing or misplaced done pulse.
- **Faulty current-context register:** this appears either at `cur_ctx` at the done pulse, or one switch later, because the save goes to the wrong slot.

The bench therefore saves distinct patterns in several contexts and reads every register back after each round trip.

// File: rtl/ctxsw_pkg.sv
package ctxsw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SAVE = 2'd1,
    ST_LOAD = 2'd2
  } sw_state_e;
endpackage

// File: rtl/ctxsw_store.sv
// Context store: one row per (context, register group), registered read port,
// separate write port, no reset so that block RAM can be inferred.
module ctxsw_store #(
  parameter int ROWS   = 16,
  parameter int LINE_W = 512,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ROW_W-1:0]  waddr,
  input  logic [LINE_W-1:0] wdata,
  input  logic [ROW_W-1:0]  raddr,
  output logic [LINE_W-1:0] rdata
);
  logic [LINE_W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ctxsw_live_file.sv
// Live register file: pipeline single write / registered read port plus
// a group-wide port used by the switch sequencer.
module ctxsw_live_file #(
  parameter int DATA_W   = 64,
  parameter int NUM_REGS = 32,
  parameter int GRP_REGS = 8,
  localparam int GRP_CNT = NUM_REGS / GRP_REGS,
  localparam int GRP_W   = $clog2(GRP_CNT),
  localparam int ADDR_W  = $clog2(NUM_REGS),
  localparam int LINE_W  = GRP_REGS * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pipe_we,
  input  logic [ADDR_W-1:0] pipe_waddr,
  input  logic [DATA_W-1:0] pipe_wdata,
  input  logic [ADDR_W-1:0] pipe_raddr,
  output logic [DATA_W-1:0] pipe_rdata,
  input  logic [GRP_W-1:0]  grp_rsel,
  output logic [LINE_W-1:0] grp_rdata,
  input  logic              grp_we,
  input  logic [GRP_W-1:0]  grp_wsel,
  input  logic [LINE_W-1:0] grp_wdata
);
  logic [DATA_W-1:0] regs [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
      pipe_rdata <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (grp_we && grp_wsel == GRP_W'(i / GRP_REGS))
          regs[i] <= grp_wdata[(i % GRP_REGS)*DATA_W +: DATA_W];
        else if (pipe_we && pipe_waddr == ADDR_W'(i))
          regs[i] <= pipe_wdata;
      end
      pipe_rdata <= regs[pipe_raddr];
    end
  end

  always_comb begin
    for (int j = 0; j < GRP_REGS; j++)
      grp_rdata[j*DATA_W +: DATA_W] = regs[ADDR_W'(int'(grp_rsel) * GRP_REGS + j)];
  end
endmodule

// File: rtl/ctxsw_seq.sv
// Switch sequencer: SAVE walks the groups into the current context's rows,
// LOAD reads the target's rows and writes each group one cycle later.
module ctxsw_seq
  import ctxsw_pkg::*;
#(
  parameter int NUM_CTX = 4,
  parameter int GRP_CNT = 4,
  localparam int CTX_W  = $clog2(NUM_CTX),
  localparam int GRP_W  = $clog2(GRP_CNT),
  localparam int ROW_W  = CTX_W + GRP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_req,
  input  logic [CTX_W-1:0] sw_ctx,
  output logic             sw_ready,
  output logic             busy,
  output logic             done,
  output logic [CTX_W-1:0] cur_ctx,
  output logic             store_we,
  output logic [ROW_W-1:0] store_waddr,
  output logic [ROW_W-1:0] store_raddr,
  output logic [GRP_W-1:0] live_rsel,
  output logic             live_we,
  output logic [GRP_W-1:0] live_wsel,
  output logic             load_zero
);
  sw_state_e        state;
  logic [GRP_W:0]   cnt;
  logic [CTX_W-1:0] tgt;
  logic [NUM_CTX-1:0] saved;
  logic             accept;

  assign accept      = sw_req && (state == ST_IDLE);
  assign sw_ready    = (state == ST_IDLE);
  assign busy        = (state != ST_IDLE);
  assign store_we    = (state == ST_SAVE);
  assign live_rsel   = cnt[GRP_W-1:0];
  assign store_waddr = {cur_ctx, cnt[GRP_W-1:0]};
  assign store_raddr = {tgt, cnt[GRP_W-1:0]};
  assign live_we     = (state == ST_LOAD) && (cnt != '0);
  assign live_wsel   = GRP_W'(cnt - 1'b1);
  assign load_zero   = !saved[tgt];

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      tgt     <= '0;
      cur_ctx <= '0;
      saved   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            if (sw_ctx == cur_ctx) begin
              done <= 1'b1;
            end else begin
              tgt   <= sw_ctx;
              cnt   <= '0;
              state <= ST_SAVE;
            end
          end
        end
        ST_SAVE: begin
          saved[cur_ctx] <= 1'b1;
          if (cnt == (GRP_W+1)'(GRP_CNT - 1)) begin
            cnt   <= '0;
            state <= ST_LOAD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_LOAD: begin
          if (cnt == (GRP_W+1)'(GRP_CNT)) begin
            cnt     <= '0;
            state   <= ST_IDLE;
            done    <= 1'b1;
            cur_ctx <= tgt;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ctx_switcher.sv
module ctx_switcher #(
  parameter int DATA_W   = 64,
  parameter int NUM_REGS = 32,
  parameter int GRP_REGS = 8,
  parameter int NUM_CTX  = 4,
  localparam int GRP_CNT = NUM_REGS / GRP_REGS,
  localparam int GRP_W   = $clog2(GRP_CNT),
  localparam int CTX_W   = $clog2(NUM_CTX),
  localparam int ADDR_W  = $clog2(NUM_REGS),
  localparam int ROWS    = NUM_CTX * GRP_CNT,
  localparam int ROW_W   = CTX_W + GRP_W,
  localparam int LINE_W  = GRP_REGS * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_req,
  input  logic [CTX_W-1:0]  sw_ctx,
  output logic              sw_ready,
  output logic              busy,
  output logic              done,
  output logic [CTX_W-1:0]  cur_ctx,
  input  logic              pipe_we,
  input  logic [ADDR_W-1:0] pipe_waddr,
  input  logic [DATA_W-1:0] pipe_wdata,
  input  logic [ADDR_W-1:0] pipe_raddr,
  output logic [DATA_W-1:0] pipe_rdata
);
  logic              store_we, live_we, load_zero;
  logic [ROW_W-1:0]  store_waddr, store_raddr;
  logic [GRP_W-1:0]  live_rsel, live_wsel;
  logic [LINE_W-1:0] save_line, store_line, load_line;

  ctxsw_seq #(.NUM_CTX(NUM_CTX), .GRP_CNT(GRP_CNT)) seq_i (
    .clk, .rst, .sw_req, .sw_ctx, .sw_ready, .busy, .done, .cur_ctx,
    .store_we, .store_waddr, .store_raddr, .live_rsel, .live_we,
    .live_wsel, .load_zero
  );

  ctxsw_store #(.ROWS(ROWS), .LINE_W(LINE_W)) store_i (
    .clk, .we(store_we), .waddr(store_waddr), .wdata(save_line),
    .raddr(store_raddr), .rdata(store_line)
  );

  // never-saved contexts read as zero without clearing the store
  assign load_line = load_zero ? '0 : store_line;

  ctxsw_live_file #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .GRP_REGS(GRP_REGS)) live_i (
    .clk, .rst,
    .pipe_we(pipe_we && !busy), .pipe_waddr, .pipe_wdata,
    .pipe_raddr, .pipe_rdata,
    .grp_rsel(live_rsel), .grp_rdata(save_line),
    .grp_we(live_we), .grp_wsel(live_wsel), .grp_wdata(load_line)
  );
endmodule

// File: rtl/ctx_switcher_chk.sv
module ctx_switcher_chk #(
  parameter int CTX_W      = 2,
  parameter int SWITCH_CYC = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             sw_req,
  input logic [CTX_W-1:0] sw_ctx,
  input logic             sw_ready,
  input logic             busy,
  input logic             done,
  input logic [CTX_W-1:0] cur_ctx
);
  logic [7:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)       run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  // R3
  switch_start_chk: assert property (@(posedge clk) disable iff (rst)
    (sw_req && sw_ready && sw_ctx != cur_ctx) |=> (busy && !done));

  // R3
  busy_len_max_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run_q < 8'(SWITCH_CYC)));

  // R3
  busy_len_exact_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_q == 8'(SWITCH_CYC)));

  // R4
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R4
  cur_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(cur_ctx));

  // R6
  same_ctx_chk: assert property (@(posedge clk) disable iff (rst)
    (sw_req && sw_ready && sw_ctx == cur_ctx) |=> (done && !busy));

  // R7
  ready_low_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sw_ready);
endmodule

bind ctx_switcher ctx_switcher_chk #(.CTX_W(CTX_W), .SWITCH_CYC(2*GRP_CNT+1)) chk_i (
  .clk, .rst, .sw_req, .sw_ctx, .sw_ready, .busy, .done, .cur_ctx
);

// File: tb/ctx_switcher_tb_top.sv
module ctx_switcher_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sw_req = 1'b0;
  logic [1:0]  sw_ctx = '0;
  logic        sw_ready, busy, done;
  logic [1:0]  cur_ctx;
  logic        pipe_we = 1'b0;
  logic [4:0]  pipe_waddr = '0;
  logic [63:0] pipe_wdata = '0;
  logic [4:0]  pipe_raddr = '0;
  logic [63:0] pipe_rdata;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctx_switcher dut_i (
    .clk, .rst, .sw_req, .sw_ctx, .sw_ready, .busy, .done, .cur_ctx,
    .pipe_we, .pipe_waddr, .pipe_wdata, .pipe_raddr, .pipe_rdata
  );

  function automatic logic [63:0] pat(int ctx, int idx);
    return {16'hA5C3, 16'(ctx + 1), 16'h3C5A, 16'(idx)} ^ 64'(ctx * 977 + idx * 31);
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [63:0] d);
    pipe_we = 1'b1; pipe_waddr = 5'(a); pipe_wdata = d;
    @(negedge clk);
    pipe_we = 1'b0;
  endtask

  task automatic rd(int a, output logic [63:0] d);
    pipe_raddr = 5'(a);
    @(negedge clk);
    d = pipe_rdata;
  endtask

  task automatic fill_ctx(int ctx);
    for (int i = 0; i < 32; i++) wr(i, pat(ctx, i));
  endtask

  task automatic verify_ctx(int ctx, bit zero, string req);
    logic [63:0] v, e;
    for (int i = 0; i < 32; i++) begin
      rd(i, v);
      e = zero ? 64'h0 : pat(ctx, i);
      chk(v === e, req, v, e);
    end
  endtask

  // issues a request and checks busy length, ready, done and cur_ctx
  task automatic do_switch(int ctx, int exp_busy, string req);
    int n = 0;
    bit rdy_ok = 1'b1;
    sw_req = 1'b1; sw_ctx = 2'(ctx);
    @(negedge clk);
    sw_req = 1'b0;
    while (busy && n < 50) begin
      if (sw_ready) rdy_ok = 1'b0;
      n++;
      @(negedge clk);
    end
    chk(n == exp_busy, {req, " busy cycles"}, 64'(n), 64'(exp_busy));
    chk(rdy_ok, "R7 ready low while busy", 64'(rdy_ok), 64'd1);
    chk(done === 1'b1, "R4 done pulse", 64'(done), 64'd1);
    chk(cur_ctx === 2'(ctx), "R4 cur_ctx at done", 64'(cur_ctx), 64'(ctx));
    @(negedge clk);
    chk(done === 1'b0, "R4 done one cycle", 64'(done), 64'd0);
  endtask

  task automatic t_reset;
    logic [63:0] v;
    chk(cur_ctx === 2'd0, "R1 cur_ctx", 64'(cur_ctx), 64'd0);
    chk(busy === 1'b0 && done === 1'b0, "R1 busy/done", 64'({busy, done}), 64'd0);
    chk(sw_ready === 1'b1, "R1 ready", 64'(sw_ready), 64'd1);
    rd(0, v);  chk(v === 64'h0, "R1 reg0", v, 64'h0);
    rd(31, v); chk(v === 64'h0, "R1 reg31", v, 64'h0);
  endtask

  task automatic t_pipe;
    logic [63:0] v;
    wr(5, 64'hDEAD_BEEF_0123_4567);
    rd(5, v); chk(v === 64'hDEAD_BEEF_0123_4567, "R2 write/read", v, 64'hDEAD_BEEF_0123_4567);
    rd(6, v); chk(v === 64'h0, "R2 neighbour untouched", v, 64'h0);
  endtask

  task automatic t_switch_fresh;
    fill_ctx(0);
    verify_ctx(0, 1'b0, "R2 fill ctx0");
    do_switch(1, 9, "R3");
    verify_ctx(1, 1'b1, "R1 unsaved ctx1 zero");
  endtask

  task automatic t_roundtrip;
    fill_ctx(1);
    do_switch(0, 9, "R3");
    verify_ctx(0, 1'b0, "R5 ctx0 restored");
    do_switch(1, 9, "R3");
    verify_ctx(1, 1'b0, "R5 ctx1 restored");
    do_switch(3, 9, "R3");
    verify_ctx(3, 1'b1, "R1 unsaved ctx3 zero");
    fill_ctx(3);
    do_switch(2, 9, "R3");
    verify_ctx(2, 1'b1, "R1 unsaved ctx2 zero");
    do_switch(3, 9, "R3");
    verify_ctx(3, 1'b0, "R5 ctx3 restored");
  endtask

  task automatic t_same;
    do_switch(3, 0, "R6");
    verify_ctx(3, 1'b0, "R6 contents unchanged");
  endtask

  task automatic t_busy_req;
    logic [63:0] v;
    int n = 0;
    bit seen_busy = 1'b0;
    sw_req = 1'b1; sw_ctx = 2'd0;
    @(negedge clk);
    sw_ctx = 2'd2;                 // held request during busy
    pipe_we = 1'b1; pipe_waddr = 5'd7; pipe_wdata = 64'hBAD0_BAD0_BAD0_BAD0;
    while (busy && n < 50) begin
      seen_busy = 1'b1;
      n++;
      @(negedge clk);
      if (n == 8) begin sw_req = 1'b0; pipe_we = 1'b0; end
    end
    sw_req = 1'b0; pipe_we = 1'b0;
    chk(seen_busy && n == 9, "R3 busy cycles under load", 64'(n), 64'd9);
    chk(cur_ctx === 2'd0, "R7 target kept", 64'(cur_ctx), 64'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(busy === 1'b0, "R7 refused request not replayed", 64'(busy), 64'd0);
    end
    rd(7, v);
    chk(v === pat(0, 7), "R8 write during busy dropped", v, pat(0, 7));
    verify_ctx(0, 1'b0, "R5 ctx0 after busy stimulus");
    do_switch(3, 9, "R3");
    verify_ctx(3, 1'b0, "R8 ctx3 save not polluted");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_pipe();
    t_switch_fresh();
    t_roundtrip();
    t_same();
    t_busy_req();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule